// File: doc/BRIEF.md
# Data Frame Payload Packer and Length Checker

This block sits on the transport side of a serial storage link and handles the payload section of data frames. On the transmit path it takes a stream of 16-bit words under a valid/ready handshake. It packs each pair of words into one 32-bit dword and hands the dwords downstream with start-of-frame and end-of-frame markers. A transfer begins with a start pulse. That pulse carries the total number of words, which an earlier setup frame supplied, since data frames have no length field of their own. A frame is closed after 2048 dwords and the next dword opens a new frame. If the word total is odd, the last dword carries the final word in its low half and zeros in its high half.

On the receive path the block works on dwords as they arrive and never holds a whole frame. It counts the dwords that lie between each start and end delimiter and adds them up across the frames of one command. It compares that total with the expected dword count captured when the command started. Any mismatch, or a frame that runs past the 2048-dword limit, raises a sticky length-error flag. The flag changes only when the command completes or when a new command starts. Frame header, CRC and link primitives are handled elsewhere.

Top module: `fis_payload_packer`

## Requirements
- R1: Words are paired in arrival order: the first word of a pair occupies `outDword[15:0]` and the second occupies `outDword[31:16]`.
- R2: When the word total is odd, the final dword carries the last word in bits 15:0 and zero in bits 31:16.
- R3: `outSof` is high on the first dword of every frame and low on all other dwords. `outEof` is high on the last dword of the transfer.
- R4: A frame holds at most 2048 dwords. The 2048th dword of a frame has `outEof` high and the next dword has `outSof` high.
- R5: While `outValid` is high and `outReady` is low, `outDword`, `outSof` and `outEof` hold steady. Every word is emitted exactly once, so a transfer of N words yields ceil(N/2) dwords.
- R6: `inReady` is low whenever no transfer is active. A start with a zero count leaves the block idle. A start pulse during an active transfer is ignored, and `txBusy` drops once the last dword is taken.
- R7: After reset `outValid`, `inReady`, `txBusy` and `rxLenErr` are all low.
- R8: On receive, if the dwords counted inside delimited frames, summed over all frames of a command, equal the expected count, `rxLenErr` stays low after `rxDone`.
- R9: If the summed count differs from the expected count, `rxLenErr` rises on the cycle after `rxDone` and not before. It then stays high through later `rxDone` pulses until `rxStart`.
- R10: A received frame that holds more than 2048 dwords sets `rxLenErr` at `rxDone`, even when the total matches.
- R11: A received dword with `rxValid` high and `rxSof` low that arrives outside a frame is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txStart | input | 1 | Pulse that starts a transmit transfer |
| txWordCount | input | CNT_W | Number of 16-bit words in the transfer, sampled on `txStart` |
| txBusy | output | 1 | Transfer in progress, including a dword still waiting at the output |
| inWord | input | WORD_W | Incoming 16-bit data word |
| inValid | input | 1 | `inWord` is valid |
| inReady | output | 1 | Block accepts `inWord` on this edge |
| outDword | output | 2*WORD_W | Packed payload dword |
| outValid | output | 1 | `outDword` is valid |
| outReady | input | 1 | Downstream takes `outDword` on this edge |
| outSof | output | 1 | Dword is the first of a frame |
| outEof | output | 1 | Dword is the last of a frame |
| rxStart | input | 1 | Pulse that starts a receive command and clears the error flag |
| rxExpected | input | CNT_W | Expected total dwords for the command, sampled on `rxStart` |
| rxValid | input | 1 | A received dword is present |
| rxSof | input | 1 | Received dword opens a frame |
| rxEof | input | 1 | Received dword closes a frame |
| rxDone | input | 1 | Command completion pulse that triggers the length comparison |
| rxLenErr | output | 1 | Sticky length-error flag |

## Verification
The assertions assume that downstream obeys the handshake: it may hold `outReady` low for any time but never withdraws a dword once it has been offered. They also assume that `rxDone` and `rxStart` never arrive in the same cycle as each other. The bench drives `outReady` and `inValid` from fixed four-cycle masks that are never all-zero, so every transfer drains. It raises `rxStart` and `rxDone` only on idle receive cycles and keeps received dwords between them. The stray-start and zero-count cases stay on the input side of the handshake, so the downstream contract is never broken.

// File: rtl/fis_pack_pkg.sv
package fis_pack_pkg;

  // Strobes from the transmit control to the packing datapath.
  typedef struct packed {
    logic latchLow;   // hold this word as the low half of a pair
    logic emitPair;   // form {inWord, held low half} into the output register
    logic emitOdd;    // form {zero, inWord} for an odd final word
    logic markSof;    // emitted dword opens a frame
    logic markEof;    // emitted dword closes a frame
    logic popOut;     // output register is taken downstream this edge
  } pk_strobe_t;

endpackage

// File: rtl/fis_pack_ctrl.sv
module fis_pack_ctrl
  import fis_pack_pkg::*;
#(
  parameter int CNT_W      = 20,
  parameter int MAX_DWORDS = 2048
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txStart,
  input  logic [CNT_W-1:0] txWordCount,
  input  logic             inValid,
  input  logic             outValid,
  input  logic             outReady,
  output logic             inReady,
  output logic             txBusy,
  output pk_strobe_t       strobe
);

  localparam int IDX_W = $clog2(MAX_DWORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_DWORDS - 1);
  localparam logic [CNT_W-1:0] ONE_WORD = CNT_W'(1);

  logic             active;
  logic             haveLow;
  logic [CNT_W-1:0] wordsLeft;
  logic [IDX_W-1:0] frameIdx;

  logic canEmit;
  logic lastWord;
  logic needSlot;
  logic accept;
  logic emitAny;
  logic startOk;

  always_comb begin
    canEmit  = !outValid || outReady;
    lastWord = (wordsLeft == ONE_WORD);
    // A word that completes a dword needs a free output slot; a low half does not.
    needSlot = haveLow || lastWord;
    inReady  = active && (!needSlot || canEmit);
    accept   = inValid && inReady;

    strobe.latchLow = accept && !haveLow && !lastWord;
    strobe.emitPair = accept && haveLow;
    strobe.emitOdd  = accept && !haveLow && lastWord;
    strobe.markSof  = (frameIdx == '0);
    strobe.markEof  = lastWord || (frameIdx == LAST_IDX);
    strobe.popOut   = outValid && outReady;

    emitAny = strobe.emitPair || strobe.emitOdd;
    startOk = txStart && !active && !outValid && (txWordCount != '0);
    txBusy  = active || outValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      haveLow   <= 1'b0;
      wordsLeft <= '0;
      frameIdx  <= '0;
    end else if (startOk) begin
      active    <= 1'b1;
      haveLow   <= 1'b0;
      wordsLeft <= txWordCount;
      frameIdx  <= '0;
    end else if (accept) begin
      wordsLeft <= wordsLeft - ONE_WORD;
      haveLow   <= strobe.latchLow;
      if (lastWord) begin
        active <= 1'b0;
      end
      if (emitAny) begin
        frameIdx <= strobe.markEof ? '0 : frameIdx + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/fis_pack_datapath.sv
module fis_pack_datapath
  import fis_pack_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  pk_strobe_t          strobe,
  input  logic [WORD_W-1:0]   inWord,
  output logic [2*WORD_W-1:0] outDword,
  output logic                outValid,
  output logic                outSof,
  output logic                outEof
);

  localparam int DWORD_W = 2 * WORD_W;

  logic [WORD_W-1:0]  lowHalf;
  logic [DWORD_W-1:0] nextDword;
  logic               emitAny;

  always_comb begin
    emitAny   = strobe.emitPair || strobe.emitOdd;
    nextDword = strobe.emitPair ? {inWord, lowHalf}
                                : {{WORD_W{1'b0}}, inWord};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowHalf <= '0;
    end else if (strobe.latchLow) begin
      lowHalf <= inWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outDword <= '0;
      outValid <= 1'b0;
      outSof   <= 1'b0;
      outEof   <= 1'b0;
    end else if (emitAny) begin
      outDword <= nextDword;
      outValid <= 1'b1;
      outSof   <= strobe.markSof;
      outEof   <= strobe.markEof;
    end else if (strobe.popOut) begin
      outValid <= 1'b0;
    end
  end

endmodule

// File: rtl/fis_rx_length.sv
module fis_rx_length #(
  parameter int CNT_W      = 20,
  parameter int MAX_DWORDS = 2048
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxStart,
  input  logic [CNT_W-1:0] rxExpected,
  input  logic             rxValid,
  input  logic             rxSof,
  input  logic             rxEof,
  input  logic             rxDone,
  output logic             rxLenErr
);

  localparam int FCNT_W = $clog2(MAX_DWORDS + 1);
  localparam logic [FCNT_W-1:0] FRAME_CAP = FCNT_W'(MAX_DWORDS);

  logic [CNT_W-1:0]  expReg;
  logic [CNT_W-1:0]  total;
  logic [FCNT_W-1:0] frameCnt;
  logic              inFrame;
  logic              overrun;

  logic takeSof;
  logic takeMid;
  logic counted;
  logic tooLong;

  always_comb begin
    takeSof = rxValid && rxSof;
    takeMid = rxValid && !rxSof && inFrame;
    counted = takeSof || takeMid;
    tooLong = takeMid && (frameCnt == FRAME_CAP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expReg   <= '0;
      total    <= '0;
      frameCnt <= '0;
      inFrame  <= 1'b0;
      overrun  <= 1'b0;
      rxLenErr <= 1'b0;
    end else if (rxStart) begin
      expReg   <= rxExpected;
      total    <= '0;
      frameCnt <= '0;
      inFrame  <= 1'b0;
      overrun  <= 1'b0;
      rxLenErr <= 1'b0;
    end else begin
      if (counted) begin
        total    <= total + CNT_W'(1);
        frameCnt <= takeSof ? FCNT_W'(1) : frameCnt + FCNT_W'(1);
        inFrame  <= !rxEof;
      end
      if (tooLong) begin
        overrun <= 1'b1;
      end
      if (rxDone) begin
        rxLenErr <= rxLenErr || overrun || (total != expReg);
      end
    end
  end

endmodule

// File: rtl/fis_payload_packer.sv
module fis_payload_packer
  import fis_pack_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int CNT_W      = 20,
  parameter int MAX_DWORDS = 2048
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                txStart,
  input  logic [CNT_W-1:0]    txWordCount,
  output logic                txBusy,
  input  logic [WORD_W-1:0]   inWord,
  input  logic                inValid,
  output logic                inReady,
  output logic [2*WORD_W-1:0] outDword,
  output logic                outValid,
  input  logic                outReady,
  output logic                outSof,
  output logic                outEof,
  input  logic                rxStart,
  input  logic [CNT_W-1:0]    rxExpected,
  input  logic                rxValid,
  input  logic                rxSof,
  input  logic                rxEof,
  input  logic                rxDone,
  output logic                rxLenErr
);

  pk_strobe_t strobe;

  fis_pack_ctrl #(
    .CNT_W      (CNT_W),
    .MAX_DWORDS (MAX_DWORDS)
  ) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .txStart     (txStart),
    .txWordCount (txWordCount),
    .inValid     (inValid),
    .outValid    (outValid),
    .outReady    (outReady),
    .inReady     (inReady),
    .txBusy      (txBusy),
    .strobe      (strobe)
  );

  fis_pack_datapath #(
    .WORD_W (WORD_W)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inWord   (inWord),
    .outDword (outDword),
    .outValid (outValid),
    .outSof   (outSof),
    .outEof   (outEof)
  );

  fis_rx_length #(
    .CNT_W      (CNT_W),
    .MAX_DWORDS (MAX_DWORDS)
  ) i_rx (
    .clk        (clk),
    .rstN       (rstN),
    .rxStart    (rxStart),
    .rxExpected (rxExpected),
    .rxValid    (rxValid),
    .rxSof      (rxSof),
    .rxEof      (rxEof),
    .rxDone     (rxDone),
    .rxLenErr   (rxLenErr)
  );

endmodule

// File: rtl/fis_packer_checker.sv
module fis_packer_checker #(
  parameter int WORD_W     = 16,
  parameter int MAX_DWORDS = 2048
) (
  input logic                clk,
  input logic                rstN,
  input logic                txBusy,
  input logic                inReady,
  input logic [2*WORD_W-1:0] outDword,
  input logic                outValid,
  input logic                outReady,
  input logic                outSof,
  input logic                outEof,
  input logic                rxStart,
  input logic                rxDone,
  input logic                rxLenErr
);

  localparam int CW = $clog2(MAX_DWORDS) + 1;

  logic          fire;
  logic          expectSof;
  logic [CW-1:0] frameDw;

  assign fire = outValid && outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expectSof <= 1'b1;
      frameDw   <= '0;
    end else if (fire) begin
      expectSof <= outEof;
      frameDw   <= outEof ? '0 : frameDw + CW'(1);
    end
  end

  // R5: an offered dword is held unchanged until taken
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outDword) && $stable(outSof) && $stable(outEof)));

  // R6: no word is taken while idle
  p_idle_noready_r6: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> !inReady);

  // R3: start marker exactly on the first dword after a frame closed
  p_sof_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outSof == expectSof));

  // R4: a frame never exceeds the dword cap
  p_frame_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fire && (frameDw == CW'(MAX_DWORDS - 1))) |-> outEof);

  // R9: the error flag moves only on completion or restart
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!rxDone && !rxStart) |=> $stable(rxLenErr));

  // R9: once raised, a completion alone never clears it
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxLenErr && !rxStart) |=> rxLenErr);

endmodule

bind fis_payload_packer fis_packer_checker #(
  .WORD_W     (WORD_W),
  .MAX_DWORDS (MAX_DWORDS)
) i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .txBusy   (txBusy),
  .inReady  (inReady),
  .outDword (outDword),
  .outValid (outValid),
  .outReady (outReady),
  .outSof   (outSof),
  .outEof   (outEof),
  .rxStart  (rxStart),
  .rxDone   (rxDone),
  .rxLenErr (rxLenErr)
);

// File: tb/test_fis_payload_packer.sv
module test_fis_payload_packer;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 16;
  localparam int CNT_W      = 20;
  localparam int MAX_DW     = 2048;

  typedef struct packed {
    logic [31:0] n;
    logic [3:0]  rMask;
    logic [3:0]  vMask;
    logic        dbl;
  } vec_t;

  localparam int NUM_VEC = 6;
  localparam vec_t VECS [NUM_VEC] = '{
    '{n: 32'd1,    rMask: 4'b1111, vMask: 4'b1111, dbl: 1'b0},
    '{n: 32'd2,    rMask: 4'b1111, vMask: 4'b1111, dbl: 1'b0},
    '{n: 32'd7,    rMask: 4'b1010, vMask: 4'b1111, dbl: 1'b1},
    '{n: 32'd8,    rMask: 4'b1111, vMask: 4'b0101, dbl: 1'b0},
    '{n: 32'd13,   rMask: 4'b0011, vMask: 4'b1101, dbl: 1'b0},
    '{n: 32'd4100, rMask: 4'b1011, vMask: 4'b1111, dbl: 1'b0}
  };

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                txStart = 1'b0;
  logic [CNT_W-1:0]    txWordCount = '0;
  logic                txBusy;
  logic [WORD_W-1:0]   inWord = '0;
  logic                inValid = 1'b0;
  logic                inReady;
  logic [2*WORD_W-1:0] outDword;
  logic                outValid;
  logic                outReady = 1'b0;
  logic                outSof;
  logic                outEof;
  logic                rxStart = 1'b0;
  logic [CNT_W-1:0]    rxExpected = '0;
  logic                rxValid = 1'b0;
  logic                rxSof = 1'b0;
  logic                rxEof = 1'b0;
  logic                rxDone = 1'b0;
  logic                rxLenErr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fis_payload_packer #(
    .WORD_W (WORD_W), .CNT_W (CNT_W), .MAX_DWORDS (MAX_DW)
  ) i_fis_payload_packer (
    .clk (clk), .rstN (rstN),
    .txStart (txStart), .txWordCount (txWordCount), .txBusy (txBusy),
    .inWord (inWord), .inValid (inValid), .inReady (inReady),
    .outDword (outDword), .outValid (outValid), .outReady (outReady),
    .outSof (outSof), .outEof (outEof),
    .rxStart (rxStart), .rxExpected (rxExpected), .rxValid (rxValid),
    .rxSof (rxSof), .rxEof (rxEof), .rxDone (rxDone), .rxLenErr (rxLenErr)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] wordOf(input int seed, input int i);
    return WORD_W'(seed + i * 257);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // One transmit transfer, dwords checked on every downstream handshake.
  task automatic runTx(input int n, input logic [3:0] rMask, input logic [3:0] vMask,
                       input bit dbl, input int seed);
    int totalDw = (n + 1) / 2;
    int wIdx = 0;
    int dIdx = 0;
    int cyc = 0;
    bit stalled = 1'b0;
    logic [2*WORD_W-1:0] held = '0;
    @(negedge clk);
    txStart = 1'b1;
    txWordCount = CNT_W'(n);
    @(negedge clk);
    txStart = 1'b0;
    check("R6", "busy after start", 64'(txBusy), 64'd1);
    while (dIdx < totalDw && cyc < 20000) begin
      if (cyc != 0) @(negedge clk);
      if (dbl && cyc == 1) begin
        txStart = 1'b1;
        txWordCount = CNT_W'(n + 10);
      end else begin
        txStart = 1'b0;
      end
      outReady = rMask[cyc % 4];
      inValid  = (wIdx < n) && vMask[cyc % 4];
      inWord   = wordOf(seed, wIdx);
      #1;
      if (stalled) begin
        check("R5", "held valid under stall", 64'(outValid), 64'd1);
        check("R5", "held dword under stall", 64'(outDword), 64'(held));
      end
      if (inValid && inReady) wIdx++;
      if (outValid && outReady) begin
        int lo = 2 * dIdx;
        logic [WORD_W-1:0] expHi = (lo + 1 < n) ? wordOf(seed, lo + 1) : '0;
        string tag = (lo + 1 < n) ? "R1" : "R2";
        string fTag = (dIdx >= MAX_DW - 1) ? "R4" : "R3";
        check(tag, "dword data", 64'(outDword), 64'({expHi, wordOf(seed, lo)}));
        check(fTag, "sof", 64'(outSof), 64'((dIdx % MAX_DW) == 0));
        check(fTag, "eof", 64'(outEof),
              64'(((dIdx % MAX_DW) == MAX_DW - 1) || (dIdx == totalDw - 1)));
        dIdx++;
      end
      stalled = outValid && !outReady;
      held = outDword;
      cyc++;
    end
    @(negedge clk);
    txStart = 1'b0;
    inValid = 1'b0;
    outReady = 1'b1;
    #1;
    check("R5", "dword total", 64'(dIdx), 64'(totalDw));
    check("R5", "words consumed", 64'(wIdx), 64'(n));
    check("R6", "idle after transfer", 64'({txBusy, outValid, inReady}), 64'd0);
  endtask

  task automatic rxBegin(input int exp);
    @(negedge clk);
    rxStart = 1'b1;
    rxExpected = CNT_W'(exp);
    @(negedge clk);
    rxStart = 1'b0;
  endtask

  task automatic rxFrame(input int len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rxValid = 1'b1;
      rxSof = (k == 0);
      rxEof = (k == len - 1);
    end
    @(negedge clk);
    rxValid = 1'b0;
    rxSof = 1'b0;
    rxEof = 1'b0;
  endtask

  task automatic rxFinish();
    @(negedge clk);
    rxDone = 1'b1;
    @(negedge clk);
    rxDone = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7", "reset outputs", 64'({outValid, inReady, txBusy, rxLenErr}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R7", "outputs after release", 64'({outValid, inReady, txBusy, rxLenErr}), 64'd0);

    // Zero-count start leaves the block idle (R6)
    txStart = 1'b1;
    txWordCount = '0;
    inValid = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
    #1;
    check("R6", "zero count stays idle", 64'({txBusy, inReady}), 64'd0);
    inValid = 1'b0;

    // Table-driven transmit transfers
    for (int v = 0; v < NUM_VEC; v++) begin
      runTx(int'(VECS[v].n), VECS[v].rMask, VECS[v].vMask, VECS[v].dbl, 16'hA5A5 ^ (v * 16'h1111));
    end

    // R8: single frame matching expected
    rxBegin(5);
    rxFrame(5);
    check("R8", "no flag before completion", 64'(rxLenErr), 64'd0);
    rxFinish();
    check("R8", "single frame match", 64'(rxLenErr), 64'd0);

    // R8: two frames summed
    rxBegin(7);
    rxFrame(3);
    rxFrame(4);
    rxFinish();
    check("R8", "multi frame match", 64'(rxLenErr), 64'd0);

    // R9: mismatch reported only at completion, then sticky
    rxBegin(6);
    rxFrame(5);
    check("R9", "silent mid command", 64'(rxLenErr), 64'd0);
    rxFinish();
    check("R9", "mismatch flagged", 64'(rxLenErr), 64'd1);
    rxFinish();
    check("R9", "flag sticky", 64'(rxLenErr), 64'd1);
    rxBegin(1);
    check("R9", "cleared by start", 64'(rxLenErr), 64'd0);

    // R10: oversize frame with matching total
    rxBegin(MAX_DW + 1);
    rxFrame(MAX_DW + 1);
    rxFinish();
    check("R10", "oversize frame", 64'(rxLenErr), 64'd1);

    // R11: stray dwords outside a frame are not counted
    rxBegin(4);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      rxValid = 1'b1;
      rxSof = 1'b0;
      rxEof = 1'b0;
    end
    @(negedge clk);
    rxValid = 1'b0;
    rxFrame(4);
    rxFinish();
    check("R11", "stray dwords ignored", 64'(rxLenErr), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule